// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

This block turns one vector memory command into a stream of per-element effective addresses. A command carries a base value, a flag marking the base register as register zero, a signed immediate offset, an element size in bytes, a vector length and an address mode. Once the command is accepted, the block presents one (element index, address) pair at a time on a valid/ready request port. It advances to the next element only when a request is accepted.

Four address modes are supported. In the strided mode, the immediate multiplied by the element index is added to the base. The packed mode steps by the element size after a fixed immediate displacement. The two update modes move the base register by the immediate once per element. The pre-update mode uses the advanced base as the address. The post-update mode uses the base before advancing it. In both update modes the final base value is reported for write-back when the command finishes. Memory access, data alignment and register writes belong to neighbouring blocks.

Top module: `vls_addr_seq`

## Requirements
- R1: Mode 2'b00 (strided) with a non-zero immediate gives element i the address base + sext(imm) * i.
- R2: Mode 2'b01 (packed) gives element i the address base + sext(imm) + elem_size * i.
- R3: Mode 2'b00 with an immediate of zero is carried out exactly as mode 2'b01.
- R4: When base_is_r0 is 1 the base is taken as zero, whatever base_val holds.
- R5: Mode 2'b11 (post-update) gives element i the address base + sext(imm) * i.
- R6: Mode 2'b10 (pre-update) gives element i the address base + sext(imm) * (i + 1).
- R7: In modes 2'b10 and 2'b11, wb_valid is high in the done cycle and wb_base equals base + vlen * sext(imm). In modes 2'b00 and 2'b01, wb_valid stays low.
- R8: A command with vlen = 0 raises no request. It pulses done in the cycle after start, and in update modes it reports wb_base equal to the unchanged base.
- R9: Requests are raised in the cycle after start. They carry element indices 0, 1, 2 … in order, moving one element per accepted handshake. While req_ready is low, the index and address hold steady.
- R10: done is high for the cycle after the last accepted request, and busy and req_valid are low in that cycle.
- R11: A start pulse while busy is high is ignored, and the running command continues unchanged.
- R12: All address and base arithmetic wraps modulo 2^64, and the immediate is sign-extended from 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken only while busy is low |
| mode | input | 2 | 00 strided, 01 packed, 10 pre-update, 11 post-update |
| base_val | input | 64 | Base register contents |
| base_is_r0 | input | 1 | Base register is register zero (base reads as 0) |
| imm | input | 16 | Signed immediate displacement |
| elem_size | input | 4 | Element size in bytes |
| vlen | input | 7 | Number of elements |
| busy | output | 1 | Command in progress |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Downstream accepts request |
| req_idx | output | 7 | Element index of the request |
| req_addr | output | 64 | Effective address of the request |
| done | output | 1 | One-cycle pulse at command end |
| wb_valid | output | 1 | Final base is valid (update modes) |
| wb_base | output | 64 | Final base value for write-back |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of a stalled burst. The bench reaches it by holding req_ready low on a fixed rhythm while it pulses start with a different command. The address stream must then carry on unchanged. Wrap-around is reached with a negative immediate on a small base, so the addresses cross zero. A zero immediate in strided mode is sent on its own so that the fallback to packed stepping can be seen.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [1:0] {
    AM_STRIDED  = 2'b00,
    AM_PACKED   = 2'b01,
    AM_UPD_PRE  = 2'b10,
    AM_UPD_POST = 2'b11
  } amode_e;

  // A zero immediate cannot stride, so strided falls back to packed stepping.
  function automatic amode_e resolve_mode(input logic [1:0] raw, input logic imm_zero);
    amode_e m;
    m = amode_e'(raw);
    if (m == AM_STRIDED && imm_zero) m = AM_PACKED;
    return m;
  endfunction

endpackage

// File: rtl/vls_cmd_decode.sv
module vls_cmd_decode
  import vls_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              base_is_r0,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SIZE_W-1:0] elem_size,
  output logic [ADDR_W-1:0] eff_base,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] step,
  output logic              is_update,
  output logic              is_pre
);

  localparam int PAD_IMM  = ADDR_W - IMM_W;
  localparam int PAD_SIZE = ADDR_W - SIZE_W;

  function automatic logic [ADDR_W-1:0] sext(input logic [IMM_W-1:0] v);
    return {{PAD_IMM{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] zext_size(input logic [SIZE_W-1:0] v);
    return {{PAD_SIZE{1'b0}}, v};
  endfunction

  amode_e            rmode;
  logic [ADDR_W-1:0] disp;

  always_comb begin
    rmode     = resolve_mode(mode, imm == '0);
    disp      = sext(imm);
    eff_base  = base_is_r0 ? '0 : base_val;
    is_update = (rmode == AM_UPD_PRE) || (rmode == AM_UPD_POST);
    is_pre    = (rmode == AM_UPD_PRE);
    unique case (rmode)
      AM_STRIDED:  begin first_addr = eff_base;        step = disp;                 end
      AM_PACKED:   begin first_addr = eff_base + disp; step = zext_size(elem_size); end
      AM_UPD_PRE:  begin first_addr = eff_base + disp; step = disp;                 end
      default:     begin first_addr = eff_base;        step = disp;                 end
    endcase
  end

endmodule

// File: rtl/vls_elem_ctr.sv
module vls_elem_ctr #(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [VL_W-1:0] vl_in,
  input  logic            adv,
  input  logic            active,
  output logic [VL_W-1:0] idx,
  output logic            is_last
);

  logic [VL_W-1:0] vl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      vl_q <= '0;
    end else if (load) begin
      idx  <= '0;
      vl_q <= vl_in;
    end else if (adv) begin
      idx  <= idx + 1'b1;
    end
  end

  assign is_last = (idx == vl_q - 1'b1);

  // R9: an active element index never reaches the loaded length
  a_r9_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx < vl_q));

  // R9: indices step by exactly one per advance
  a_r9_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/vls_addr_accum.sv
module vls_addr_accum #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] step_in,
  input  logic              pre_in,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] final_base
);

  logic [ADDR_W-1:0] step_q;
  logic              pre_q;
  logic [ADDR_W-1:0] next_addr;

  assign next_addr = addr + step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      step_q <= '0;
      pre_q  <= 1'b0;
    end else if (load) begin
      addr   <= first_addr;
      step_q <= step_in;
      pre_q  <= pre_in;
    end else if (adv) begin
      addr   <= next_addr;
    end
  end

  // Pre-update already points past the base; post-update needs one more step.
  assign final_base = pre_q ? addr : next_addr;

  // R12: consecutive addresses differ by the latched step, modulo 2^64
  a_r12_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (addr == $past(addr) + $past(step_q)));

  // R9: address holds when neither loaded nor advanced
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(addr));

endmodule

// File: rtl/vls_addr_seq.sv
module vls_addr_seq
  import vls_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 16,
  parameter int SIZE_W = 4,
  parameter int VL_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              base_is_r0,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SIZE_W-1:0] elem_size,
  input  logic [VL_W-1:0]   vlen,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [VL_W-1:0]   req_idx,
  output logic [ADDR_W-1:0] req_addr,
  output logic              done,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_base
);

  logic [ADDR_W-1:0] dec_base, dec_first, dec_step, acc_final;
  logic              dec_upd, dec_pre;
  logic              busy_q, upd_q, done_q, wbv_q;
  logic [ADDR_W-1:0] wb_q;
  logic              is_last;

  // Named events for the assertions
  logic accept, empty_cmd, hs, last_hs;

  vls_cmd_decode #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W)) u_dec (
    .mode(mode), .base_val(base_val), .base_is_r0(base_is_r0), .imm(imm),
    .elem_size(elem_size), .eff_base(dec_base), .first_addr(dec_first),
    .step(dec_step), .is_update(dec_upd), .is_pre(dec_pre)
  );

  assign accept    = start && !busy_q;
  assign empty_cmd = accept && (vlen == '0);
  assign hs        = busy_q && req_ready;
  assign last_hs   = hs && is_last;

  vls_elem_ctr #(.VL_W(VL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(accept), .vl_in(vlen), .adv(hs),
    .active(busy_q), .idx(req_idx), .is_last(is_last)
  );

  vls_addr_accum #(.ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(accept), .first_addr(dec_first),
    .step_in(dec_step), .pre_in(dec_pre), .adv(hs), .addr(req_addr),
    .final_base(acc_final)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      upd_q  <= 1'b0;
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
      wb_q   <= '0;
    end else begin
      done_q <= empty_cmd || last_hs;
      wbv_q  <= (empty_cmd && dec_upd) || (last_hs && upd_q);
      if (accept) begin
        busy_q <= (vlen != '0);
        upd_q  <= dec_upd;
      end else if (last_hs) begin
        busy_q <= 1'b0;
      end
      if (empty_cmd)    wb_q <= dec_base;
      else if (last_hs) wb_q <= acc_final;
    end
  end

  assign busy      = busy_q;
  assign req_valid = busy_q;
  assign done      = done_q;
  assign wb_valid  = wbv_q;
  assign wb_base   = wb_q;

  // R8: an empty command never raises a request and finishes at once
  a_r8_empty_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlen == '0) |=> (!req_valid && done));

  // R10: the done cycle is an idle cycle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !req_valid));

  // R7: a write-back is only reported at the end of a command
  a_r7_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  // R11: a start while busy does not disturb a stalled request
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_idx)));

  // R9: a stalled request is held
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_idx)));

endmodule

// File: tb/vls_addr_seq_tb.sv
module vls_addr_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] base_val = '0;
  logic        base_is_r0 = 1'b0;
  logic [15:0] imm = '0;
  logic [3:0]  elem_size = '0;
  logic [6:0]  vlen = '0;
  logic        req_ready = 1'b0;
  logic        busy, req_valid, done, wb_valid;
  logic [6:0]  req_idx;
  logic [63:0] req_addr, wb_base;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vls_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_val(base_val),
    .base_is_r0(base_is_r0), .imm(imm), .elem_size(elem_size), .vlen(vlen),
    .busy(busy), .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .req_addr(req_addr), .done(done), .wb_valid(wb_valid), .wb_base(wb_base)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference model: address of element i, written as a product
  function automatic logic [63:0] ref_addr(input logic [1:0] m, input logic [63:0] b,
                                           input logic [15:0] im, input logic [3:0] sz,
                                           input int i);
    logic [63:0] d, ii;
    d  = {{48{im[15]}}, im};
    ii = 64'(i);
    if (m == 2'b00 && im == 16'd0) m = 2'b01;
    case (m)
      2'b00:   return b + d * ii;
      2'b01:   return b + d + {60'd0, sz} * ii;
      2'b10:   return b + d * (ii + 64'd1);
      default: return b + d * ii;
    endcase
  endfunction

  task automatic run_cmd(input logic [1:0] m, input logic [63:0] b, input bit r0,
                         input logic [15:0] im, input logic [3:0] sz, input int vl,
                         input bit stall, input bit poke, input string tag);
    logic [63:0] eb;
    int k;
    int cyc;
    bit poked;
    eb = r0 ? 64'd0 : b;
    @(negedge clk);
    start = 1'b1; mode = m; base_val = b; base_is_r0 = r0; imm = im;
    elem_size = sz; vlen = 7'(vl); req_ready = 1'b0;
    k = 0; cyc = 0; poked = 1'b0;
    while (k < vl) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 1 && !poked) begin
        // R11: a new command pushed while busy must be ignored
        start = 1'b1; mode = 2'b01; base_val = 64'hdead_0000; imm = 16'h7; vlen = 7'd9;
        poked = 1'b1;
      end
      chk(req_valid === 1'b1 && done === 1'b0, {tag, " R9 valid"}, {62'd0, req_valid, done}, 64'd2);
      chk(req_idx === 7'(k), {tag, " R9 index"}, 64'(req_idx), 64'(k));
      chk(req_addr === ref_addr(m, eb, im, sz, k), {tag, " address"}, req_addr, ref_addr(m, eb, im, sz, k));
      req_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      if (req_ready) k++;
      cyc++;
    end
    @(negedge clk);
    start = 1'b0; req_ready = 1'b0;
    chk(done === 1'b1 && busy === 1'b0 && req_valid === 1'b0, {tag, " R10 done"},
        {61'd0, done, busy, req_valid}, 64'd4);
    chk(wb_valid === m[1], {tag, " R7 wb_valid"}, 64'(wb_valid), 64'(m[1]));
    if (m[1])
      chk(wb_base === eb + {{48{im[15]}}, im} * 64'(vl), {tag, " R7 wb_base"},
          wb_base, eb + {{48{im[15]}}, im} * 64'(vl));
    @(negedge clk);
    chk(done === 1'b0 && req_valid === 1'b0, {tag, " R10 pulse"}, {62'd0, done, req_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_valid === 1'b0 && done === 1'b0 && busy === 1'b0 && wb_valid === 1'b0,
        "reset R10", {60'd0, req_valid, done, busy, wb_valid}, 64'd0);
    rst_n = 1'b1;
    run_cmd(2'b00, 64'd16, 1'b0, 16'd24, 4'd4, 2, 1'b0, 1'b0, "R1 strided");
    run_cmd(2'b01, 64'd16, 1'b0, 16'd8, 4'd4, 2, 1'b0, 1'b0, "R2 packed");
    run_cmd(2'b00, 64'h100, 1'b0, 16'd0, 4'd8, 3, 1'b0, 1'b0, "R3 zero-imm");
    run_cmd(2'b00, 64'hffff_1234, 1'b1, 16'd4, 4'd4, 3, 1'b0, 1'b0, "R4 r0");
    run_cmd(2'b11, 64'd16, 1'b0, 16'd24, 4'd4, 2, 1'b0, 1'b0, "R5 post");
    run_cmd(2'b10, 64'd16, 1'b0, 16'd24, 4'd4, 2, 1'b0, 1'b0, "R6 pre");
    run_cmd(2'b11, 64'd8, 1'b0, 16'hfff0, 4'd8, 4, 1'b1, 1'b0, "R12 wrap");
    run_cmd(2'b10, 64'd40, 1'b1, 16'hffe8, 4'd2, 3, 1'b1, 1'b0, "R12 r0 pre");
    run_cmd(2'b00, 64'h2000, 1'b0, 16'd12, 4'd4, 6, 1'b1, 1'b1, "R11 poke");
    // R8: empty command in update mode
    @(negedge clk);
    start = 1'b1; mode = 2'b10; base_val = 64'h77; base_is_r0 = 1'b0; imm = 16'd5; vlen = 7'd0;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1 && req_valid === 1'b0 && busy === 1'b0, "R8 empty done",
        {61'd0, done, req_valid, busy}, 64'd4);
    chk(wb_valid === 1'b1 && wb_base === 64'h77, "R8 empty base", wb_base, 64'h77);
    @(negedge clk);
    chk(req_valid === 1'b0 && done === 1'b0, "R8 quiet", {62'd0, req_valid, done}, 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule